// File: doc/BRIEF.md
# Sequential Continuity Test Scanner

The scanner tests up to twelve wired connections one after another. For each channel in turn it raises that channel's select line, so an external driver puts a test level on the connection. It then watches one return line that all channels share. If the return is high while the channel is selected, the channel is credited with a pass. Each channel has its own pass flag, and the flag stays set until the next scan is started. A scan begins on a one-cycle start pulse, steps through the channels from 0 upward, and then stops with every select low and a done flag raised.

Timing comes from a timebase unit. A unit is one slow tick from an outside timebase, further divided by an internal ratio. Each channel's step lasts a fixed number of units. The step opens with a blanking interval, during which the return is ignored. The sampling strobe window follows it. A driver that is still letting go of the previous channel therefore cannot credit the newly selected one. At the close of the strobe window the scanner judges the channel. The first channel found without a return raises a one-cycle alarm, and its index is kept for read-back. The return input passes through a two-flop synchronizer before it is used.

Top module: `cont_scan`

## Requirements
- R1: No more than one select line is high in any clock cycle. While a scan runs, the line that is high is the one whose number equals the channel index output. While idle or done, every select line is low.
- R2: A scan visits channels 0, 1, … NUM_CH-1 in order, each exactly once. With the tick held high, each channel is selected for STEP_UNITS×TICK_DIV clock cycles.
- R3: A channel's pass flag is set only if the synchronized return is high inside that channel's strobe window. A return that is present only during the blanking interval after a channel change sets no flag.
- R4: A pass flag, once set, stays set until the next start pulse.
- R5: A start pulse clears every pass flag, the done flag, the alarm, the failure-seen flag and the failure index. It sets the channel index to 0 and begins a scan. This holds even when a scan is already running.
- R6: After the last channel's step ends, all selects are low and done is high. Until the next start, the return has no effect on the pass flags or the alarm.
- R7: The alarm is a one-cycle pulse raised at most once per scan. It is raised at the end of the strobe window of the lowest-numbered channel that saw no return, while that channel is still selected. The failure index then holds that channel number, and the failure-seen flag stays high, until the next start.
- R8: While the step tick is low, the step timing stops: the channel index and the selects keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse: clear results and begin a scan |
| step_tick | input | 1 | Slow timebase tick, divided by TICK_DIV into units |
| ret_in | input | 1 | Shared return line, asynchronous |
| sel_o | output | NUM_CH | One-hot channel select lines |
| pass_o | output | NUM_CH | Sticky per-channel pass flags |
| idx_o | output | IDX_W | Current channel index |
| done_o | output | 1 | Scan complete |
| alarm_o | output | 1 | One-cycle first-failure pulse |
| fail_seen_o | output | 1 | A failing channel was found in this scan |
| fail_idx_o | output | IDX_W | Index of the first failing channel |

## Verification
The embedded properties check, on every cycle, the following:
- at most one select line is high;
- the index moves only at a step end, and then by exactly one;
- the index and the phase freeze while no unit is present;
- pass flags never drop, and change only inside a strobe window;
- the alarm is a single pulse that cannot repeat after a failure is recorded;
- a start pulse clears the results;
- a finished scan stays inert.

Other properties depend on the stimulus, so only the bench scenarios show them:
- the final pass pattern matches the wiring;
- a lingering return from a good channel gives no false credit to the bad channel after it;
- the alarm marks the lowest failing channel;
- each step lasts exactly the expected number of cycles.

// File: rtl/cs_pkg.sv
// Package: shared types for the continuity scanner.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cs_pkg;

    // Scan control state: idle after reset, running a scan, or finished.
    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_RUN  = 2'd1,
        SCAN_DONE = 2'd2
    } scan_state_e;

    // Width helper that never returns zero.
    function automatic int safe_clog2(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cs_sync.sv
// Module: cs_sync
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flops. Assumes STAGES >= 2 and that the input is a slow level.
module cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage captures the raw asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later stages pass the level down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/cs_timebase.sv
// Module: cs_timebase
// Divides the external slow tick by DIV. The unit enable is high for one
// clock in every DIV cycles in which the tick is high. Assumes DIV >= 1.
// A clear restarts the division so that a scan begins on a full unit.
module cs_timebase #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_in,
    output logic unit_en
);

    localparam int CW = cs_pkg::safe_clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Counts ticks and wraps after DIV of them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (tick_in)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign unit_en = tick_in && (cnt == LAST);

    // R8: with no tick there is no unit and the count holds.
    p_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !clr) |=> $stable(cnt));

endmodule

// File: rtl/cs_phase.sv
// Module: cs_phase
// Tracks the position inside one channel step, in timebase units. It flags
// the strobe window (after blanking), its last unit, and the step end.
// Assumes 1 <= BLANK and BLANK + STROBE < STEP. The phase is zeroed by a
// clear and wraps at each step end.
module cs_phase #(
    parameter int STEP   = 10,
    parameter int BLANK  = 5,
    parameter int STROBE = 3,
    localparam int PW    = cs_pkg::safe_clog2(STEP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          unit_en,
    output logic [PW-1:0] ph,
    output logic          strobe,
    output logic          strobe_last,
    output logic          step_end
);

    localparam logic [PW-1:0] PH_LAST  = PW'(STEP - 1);
    localparam logic [PW-1:0] WIN_LO   = PW'(BLANK);
    localparam logic [PW-1:0] WIN_HI   = PW'(BLANK + STROBE - 1);

    // Advances the phase by one unit while running; wraps at the step end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        ph <= '0;
        else if (run && unit_en)  ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
    end

    // Decodes the blanking/strobe split of the step.
    always_comb begin
        strobe      = run && (ph >= WIN_LO) && (ph <= WIN_HI);
        strobe_last = strobe && unit_en && (ph == WIN_HI);
        step_end    = run && unit_en && (ph == PH_LAST);
    end

    // R8: with no unit the phase does not move.
    p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_en && !clr) |=> $stable(ph));

endmodule

// File: rtl/cs_chan.sv
// Module: cs_chan
// Owns the scan state and the channel index, and decodes the one-hot
// selects. A clear starts a scan at channel 0. Each step end moves on by
// one channel; the step end of the last channel ends the scan.
// Assumes step_end is only high while running.
module cs_chan #(
    parameter int NUM_CH  = 12,
    localparam int IW     = cs_pkg::safe_clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step_end,
    output logic [IW-1:0]     idx,
    output logic [NUM_CH-1:0] sel,
    output logic              running,
    output logic              done
);

    import cs_pkg::*;

    localparam logic [IW-1:0] IDX_LAST = IW'(NUM_CH - 1);

    scan_state_e state;

    // Scan sequencing: start, step through channels, stop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SCAN_IDLE;
            idx   <= '0;
        end else if (clr) begin
            state <= SCAN_RUN;
            idx   <= '0;
        end else if (state == SCAN_RUN && step_end) begin
            if (idx == IDX_LAST) state <= SCAN_DONE;
            else                 idx   <= idx + 1'b1;
        end
    end

    assign running = (state == SCAN_RUN);
    assign done    = (state == SCAN_DONE);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        // One select line per channel, high only for the active index.
        assign sel[c] = running && (idx == IW'(c));
    end

    // R1: never two selects at once.
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R2: the index holds between step ends.
    p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step_end) |=> $stable(idx));

    // R2: a step end inside a scan moves to the next channel.
    p_idx_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && running && step_end && idx != IDX_LAST)
            |=> idx == IW'($past(idx) + 1'b1));

endmodule

// File: rtl/cs_judge.sv
// Module: cs_judge
// Holds the sticky pass flags and the first-failure record. A pass is
// credited to the active channel only in the strobe window. At the last
// strobe unit, a channel with no pass is judged failed. The first such
// channel per scan pulses the alarm. Assumes idx < NUM_CH.
module cs_judge #(
    parameter int NUM_CH  = 12,
    localparam int IW     = cs_pkg::safe_clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              strobe,
    input  logic              strobe_last,
    input  logic [IW-1:0]     idx,
    input  logic              ret_s,
    output logic [NUM_CH-1:0] pass,
    output logic              alarm,
    output logic              fail_seen,
    output logic [IW-1:0]     fail_idx
);

    logic [NUM_CH-1:0] hit;
    logic              cur_pass;
    logic              cur_fail;

    // Builds the credit mask for the active channel during the strobe.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            hit[c] = strobe && ret_s && (idx == IW'(c));
        end
        cur_pass = |(pass & ~hit) | |hit ? ((pass | hit) >> idx) != '0 && ((pass | hit) & (NUM_CH'(1) << idx)) != '0 : 1'b0;
        cur_fail = strobe_last && !cur_pass;
    end

    // Sticky pass flags: set by a hit, cleared only by a start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pass <= '0;
        else               pass <= pass | hit;
    end

    // First-failure record and its one-cycle alarm.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            alarm     <= 1'b0;
            fail_seen <= 1'b0;
            fail_idx  <= '0;
        end else if (cur_fail && !fail_seen) begin
            alarm     <= 1'b1;
            fail_seen <= 1'b1;
            fail_idx  <= idx;
        end else begin
            alarm     <= 1'b0;
        end
    end

    // R4: pass flags never fall without a start.
    p_pass_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (pass & $past(pass)) == $past(pass));

    // R3: flags change only inside a strobe window.
    p_pass_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !strobe) |=> pass == $past(pass));

    // R7: the alarm lasts one cycle.
    p_alarm_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clr) |=> !alarm);

    // R7: no alarm once a failure is already recorded.
    p_alarm_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> !$past(fail_seen));

    // R7: the recorded index holds until a start.
    p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_seen && !clr) |=> (fail_seen && $stable(fail_idx)));

endmodule

// File: rtl/cont_scan.sv
// Module: cont_scan (top)
// Sequential continuity scanner: one-hot channel selects, a blanked and
// strobed look at the shared return, sticky pass flags and a first-failure
// alarm. Assumes start is a one-cycle pulse, step_tick is synchronous to
// clk, and ret_in may be asynchronous.
module cont_scan #(
    parameter int NUM_CH       = 12,
    parameter int TICK_DIV     = 2,
    parameter int STEP_UNITS   = 10,
    parameter int BLANK_UNITS  = 5,
    parameter int STROBE_UNITS = 3,
    localparam int IDX_W       = cs_pkg::safe_clog2(NUM_CH),
    localparam int PH_W        = cs_pkg::safe_clog2(STEP_UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step_tick,
    input  logic              ret_in,
    output logic [NUM_CH-1:0] sel_o,
    output logic [NUM_CH-1:0] pass_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              done_o,
    output logic              alarm_o,
    output logic              fail_seen_o,
    output logic [IDX_W-1:0]  fail_idx_o
);

    if (BLANK_UNITS < 1 || BLANK_UNITS + STROBE_UNITS >= STEP_UNITS
        || STROBE_UNITS < 1 || NUM_CH < 2 || TICK_DIV < 1) begin : g_bad_cfg
        $error("cont_scan: blanking and strobe must fit inside the step");
    end

    logic              ret_s;
    logic              unit_en;
    logic              running;
    logic [PH_W-1:0]   ph;
    logic              strobe;
    logic              strobe_last;
    logic              step_end;

    cs_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ret_in),
        .q     (ret_s)
    );

    cs_timebase #(.DIV(TICK_DIV)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .tick_in (step_tick),
        .unit_en (unit_en)
    );

    cs_phase #(
        .STEP   (STEP_UNITS),
        .BLANK  (BLANK_UNITS),
        .STROBE (STROBE_UNITS)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (start),
        .run         (running),
        .unit_en     (unit_en),
        .ph          (ph),
        .strobe      (strobe),
        .strobe_last (strobe_last),
        .step_end    (step_end)
    );

    cs_chan #(.NUM_CH(NUM_CH)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start),
        .step_end (step_end),
        .idx      (idx_o),
        .sel      (sel_o),
        .running  (running),
        .done     (done_o)
    );

    cs_judge #(.NUM_CH(NUM_CH)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (start),
        .strobe      (strobe),
        .strobe_last (strobe_last),
        .idx         (idx_o),
        .ret_s       (ret_s),
        .pass        (pass_o),
        .alarm       (alarm_o),
        .fail_seen   (fail_seen_o),
        .fail_idx    (fail_idx_o)
    );

    // R5: a start pulse leaves a fresh scan at channel 0.
    p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pass_o == '0 && !done_o && !alarm_o && !fail_seen_o
                   && idx_o == '0 && running));

    // R6: a finished scan stays finished and inert until a start.
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> (done_o && sel_o == '0 && $stable(pass_o)
                                && !alarm_o));

    // R3: no credit can be given in the blanking part of a step.
    p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ph < PH_W'(BLANK_UNITS)) |-> !strobe);

endmodule

// File: tb/tb_cont_scan.sv
// Directed bench for cont_scan. A wiring model drives the shared return from
// the selects. A good channel returns high, and a return lingers LINGER
// cycles after its select drops, so a slow-release driver is mimicked.
module tb_cont_scan;

    localparam int CLK_P   = 10;
    localparam int NCH     = 12;
    localparam int DIV     = 2;
    localparam int STEP    = 10;
    localparam int BLANK   = 5;
    localparam int STROBE  = 3;
    localparam int LINGER  = 3;
    localparam int STEP_CYC = STEP * DIV;
    localparam int IW      = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            step_tick = 1'b1;
    logic            ret_in = 1'b0;
    logic [NCH-1:0]  sel_o, pass_o;
    logic [IW-1:0]   idx_o, fail_idx_o;
    logic            done_o, alarm_o, fail_seen_o;

    cont_scan #(
        .NUM_CH(NCH), .TICK_DIV(DIV), .STEP_UNITS(STEP),
        .BLANK_UNITS(BLANK), .STROBE_UNITS(STROBE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .step_tick(step_tick),
        .ret_in(ret_in), .sel_o(sel_o), .pass_o(pass_o), .idx_o(idx_o),
        .done_o(done_o), .alarm_o(alarm_o), .fail_seen_o(fail_seen_o),
        .fail_idx_o(fail_idx_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Wiring model and monitor state.
    logic [NCH-1:0] good_mask = '0;
    logic           ret_force = 1'b0;
    int             linger = 0;
    int             alarm_cnt = 0;
    int             alarm_at = -1;
    int             multi_err = 0, match_err = 0, order_err = 0;
    int             dur_err = 0, drop_err = 0;
    int             dur = 0;
    bit             chk_dur = 1'b1;
    logic [IW-1:0]  prev_idx = '0;
    logic [NCH-1:0] prev_pass = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Samples a quarter period after each rising edge and drives the return.
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (rst_n) begin
            if ($countones(sel_o) > 1) multi_err++;
            if (sel_o != '0 && sel_o != (NCH'(1) << idx_o)) match_err++;
            if (idx_o != prev_idx) begin
                if (idx_o != prev_idx + 1'b1 && idx_o != '0) order_err++;
                if (chk_dur && prev_idx >= 1 && idx_o == prev_idx + 1'b1
                    && dur != STEP_CYC) dur_err++;
                dur = 1;
            end else begin
                dur++;
            end
            if (((prev_pass & ~pass_o) != '0) && !start) drop_err++;
            if (alarm_o) begin
                alarm_cnt++;
                alarm_at = int'(idx_o);
            end
            prev_idx  = idx_o;
            prev_pass = pass_o;
        end
        if (ret_force) begin
            ret_in = 1'b1;
        end else if ((sel_o & good_mask) != '0) begin
            ret_in = 1'b1;
            linger = LINGER;
        end else if (linger > 0) begin
            ret_in = 1'b1;
            linger--;
        end else begin
            ret_in = 1'b0;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done_o; i++) @(negedge clk);
    endtask

    // Runs a full scan on a wiring pattern and checks the outcome.
    task automatic run_scan(input logic [NCH-1:0] mask, input string name);
        int first = -1;
        for (int c = NCH - 1; c >= 0; c--) if (!mask[c]) first = c;
        good_mask = mask;
        alarm_cnt = 0;
        alarm_at  = -1;
        pulse_start();
        // R5: state directly after start.
        chk(pass_o == '0 && !done_o && !fail_seen_o, {"R5 clear ", name}, int'(pass_o), 0);
        chk(idx_o == '0 && sel_o == NCH'(1), {"R5 index/select ", name}, int'(sel_o), 1);
        wait_done();
        @(negedge clk);
        // R3: credited pattern equals the wiring, lingering returns ignored.
        chk(pass_o == mask, {"R3 pass pattern ", name}, int'(pass_o), int'(mask));
        // R6: scan stopped with selects low.
        chk(done_o && sel_o == '0, {"R6 stopped ", name}, int'(sel_o), 0);
        // R7: alarm count, place and record.
        chk(alarm_cnt == ((first >= 0) ? 1 : 0), {"R7 alarm count ", name}, alarm_cnt, (first >= 0) ? 1 : 0);
        if (first >= 0) begin
            chk(alarm_at == first, {"R7 alarm channel ", name}, alarm_at, first);
            chk(fail_seen_o && int'(fail_idx_o) == first, {"R7 fail index ", name}, int'(fail_idx_o), first);
        end else begin
            chk(!fail_seen_o, {"R7 no failure ", name}, int'(fail_seen_o), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sel_o == '0 && pass_o == '0, "R1 reset selects/flags", int'(sel_o | pass_o), 0);
        chk(!done_o && !alarm_o && !fail_seen_o && idx_o == '0, "R6 reset status", int'(done_o), 0);
    endtask

    task automatic t_all_good();   run_scan(12'hFFF, "all good");   endtask
    task automatic t_alternate();  run_scan(12'h555, "alternate");  endtask
    task automatic t_none();       run_scan(12'h000, "none");       endtask
    task automatic t_split();      run_scan(12'hF0F, "split");      endtask

    // R6: once done, a constant return changes nothing.
    task automatic t_after_done();
        logic [NCH-1:0] held = pass_o;
        int a0 = alarm_cnt;
        ret_force = 1'b1;
        repeat (60) @(negedge clk);
        chk(pass_o == held, "R6 flags frozen after done", int'(pass_o), int'(held));
        chk(done_o && sel_o == '0 && alarm_cnt == a0, "R6 quiet after done", alarm_cnt, a0);
        ret_force = 1'b0;
        repeat (LINGER + 4) @(negedge clk);
    endtask

    // R5: a start mid-scan clears the results and restarts at channel 0.
    task automatic t_restart();
        good_mask = 12'hFFF;
        pulse_start();
        repeat (5 * STEP_CYC) @(negedge clk);
        chk(pass_o != '0, "R4 flags gathered before restart", int'(pass_o), 1);
        good_mask = 12'h000;
        pulse_start();
        chk(pass_o == '0 && idx_o == '0 && !done_o, "R5 mid-scan restart", int'(pass_o), 0);
        alarm_cnt = 0;
        wait_done();
        @(negedge clk);
        chk(pass_o == '0 && alarm_cnt == 1 && fail_idx_o == '0, "R5 restarted scan outcome", int'(pass_o), 0);
    endtask

    // R8: holding the tick low freezes the scan in place.
    task automatic t_pause();
        logic [IW-1:0]  i0;
        logic [NCH-1:0] s0;
        good_mask = 12'hFFF;
        pulse_start();
        repeat (3 * STEP_CYC + 4) @(negedge clk);
        chk_dur = 1'b0;
        step_tick = 1'b0;
        i0 = idx_o;
        s0 = sel_o;
        repeat (4 * STEP_CYC) @(negedge clk);
        chk(idx_o == i0 && sel_o == s0, "R8 hold while tick low", int'(idx_o), int'(i0));
        step_tick = 1'b1;
        wait_done();
        @(negedge clk);
        chk(pass_o == 12'hFFF, "R8 scan completes after resume", int'(pass_o), 12'hFFF);
        chk_dur = 1'b1;
    endtask

    initial begin
        t_reset();
        t_all_good();
        t_after_done();
        t_alternate();
        t_none();
        t_split();
        t_restart();
        t_pause();
        chk(multi_err == 0, "R1 no two selects together", multi_err, 0);
        chk(match_err == 0, "R1 select follows index", match_err, 0);
        chk(order_err == 0, "R2 channel order", order_err, 0);
        chk(dur_err == 0, "R2 step length", dur_err, 0);
        chk(drop_err == 0, "R4 flags never drop", drop_err, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule